// File: doc/BRIEF.md
# Write-Protected GPIO Bank Register File

This block is the register file of a memory-mapped general-purpose I/O controller. Pins are grouped into banks of 32. Each bank has registers that show the driven outputs and the synchronised pad inputs. Two further registers raise or lower outputs one bit at a time, a write-one-to-set register and a write-one-to-clear register. Each pin also has its own control word, and bit 0 of that word picks the pin's direction. The pad drivers sit outside the block. The block supplies a per-pin output value, an output enable and the full control word for each pin. Edge detection belongs to a neighbouring block. This block only decodes that neighbour's pending-status and mask registers: it reads back the pending bits, holds the mask, and turns status writes into one-cycle acknowledge pulses.

Every bank is write-protected. Software first writes a fixed password to a global register. The very next bus write, if it goes to a bank's lock register, opens that bank with the value 0x00000000 or closes it with 0xFFFFFFFF. While a bank is closed, writes to its output, mask, status and control registers are dropped. Reads are never blocked. The bank count is a parameter, from 1 up to 8.

Top module: `pinbank_regfile`

## Requirements
- R1: After reset every bank is locked, pin_out is all zeros, irq_mask is all ones, irq_ack is zero, and every control word reads 1, so each pin is an input and pin_oe is zero.
- R2: A write of 0x00A5A501 to byte address 0x520, followed by a write of 0x00000000 to 0x500+4*b, unlocks bank b. The same sequence with 0xFFFFFFFF relocks it. A lock register reads 0x00000000 when its bank is open and 0xFFFFFFFF when it is closed, and other banks keep their state.
- R3: A password write arms only the next bus write, whatever that write is. A lock write that is not immediately preceded by a correct password write changes nothing. A wrong password value does not arm. An armed lock write with any value other than the two codes changes nothing.
- R4: While bank b is locked, writes to its set, clear, status, mask and mask-clear registers and to the control words of its pins have no effect on pin_out, pin_cfg, pin_oe, irq_mask or irq_ack.
- R5: A write to 0x040+4*b sets output bit i of bank b (global pin 32*b+i) for each 1 in the data and leaves the other bits unchanged.
- R6: A write to 0x060+4*b clears output bit i of bank b for each 1 in the data and leaves the other bits unchanged.
- R7: A read of 0x000+4*b returns bank b's driven output bits, equal to pin_out[32*b+31:32*b]. A read of the set or clear register returns 0.
- R8: A read of 0x020+4*b returns pad_in of bank b through a two-flop synchroniser. A pad change shows after the second rising clock edge and not after the first.
- R9: Pin p's control word sits at 0x100+4*p. A write stores data bits CTRL_W-1:0, a read returns them with the upper bits zero, pin_cfg carries them, and pin_oe[p] is the inverse of bit 0 (1 = input, 0 = output).
- R10: A write to 0x0A0+4*b loads bank b's mask. A write to 0x0C0+4*b clears each mask bit written as 1. Both registers read the current mask.
- R11: A read of 0x080+4*b returns irq_pend_in for bank b. A write there drives irq_ack for that bank with the written bits for exactly one cycle, starting at the clock edge that takes the write.
- R12: An address beyond the configured banks or pins, or one in an unused group, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS | Raw pad levels |
| pin_out | output | NUM_PINS | Driven output value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_cfg | output | NUM_PINS*CTRL_W | Control word of every pin |
| irq_pend_in | input | NUM_PINS | Pending bits from the edge detector |
| irq_mask | output | NUM_PINS | Interrupt mask, 1 = masked |
| irq_ack | output | NUM_PINS | One-cycle acknowledge pulses |

## Verification
The set and clear registers are driven with walking ones, alternating patterns and all-zero data, which separates set from clear, full-word writes from single-bit writes, and a stuck or shifted bit from a correct one. Every control word of a two-bank build gets a distinct value with junk in the upper bits, which checks pin decoding, field truncation and the direction-to-enable inversion. The unlock sequence is tried in its correct order and also with a missing password, a wrong password, an intervening write, a double password and an unknown code. This separates "armed for one write" from "armed until used". Pad patterns are read one and two edges after they change, which shows the synchroniser depth exactly.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 12;
  localparam int BANK_PINS = 32;

  localparam logic [31:0] PASSKEY   = 32'h00A5_A501;
  localparam logic [31:0] CODE_OPEN = 32'h0000_0000;
  localparam logic [31:0] CODE_SHUT = 32'hFFFF_FFFF;

  // word-address landmarks (byte address >> 2)
  localparam logic [6:0] LOCK_PAGE       = 7'h28;   // 0x500..0x51F
  localparam logic [9:0] PASS_WORD       = 10'h148; // 0x520
  localparam logic [9:0] CTRL_FIRST_WORD = 10'h040; // 0x100

  typedef enum logic [2:0] {
    GRP_OUT_STAT   = 3'd0,
    GRP_IN_STAT    = 3'd1,
    GRP_OUT_SET    = 3'd2,
    GRP_OUT_CLR    = 3'd3,
    GRP_IRQ_STAT   = 3'd4,
    GRP_IRQ_MASK   = 3'd5,
    GRP_IRQ_UNMASK = 3'd6,
    GRP_SPARE      = 3'd7
  } bank_grp_e;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_BANK = 3'd1,
    ACC_CTRL = 3'd2,
    ACC_LOCK = 3'd3,
    ACC_PASS = 3'd4
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e kind;
    bank_grp_e grp;
    logic [7:0] idx;   // bank index or global pin index
  } acc_dec_t;

  function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int nbanks);
    acc_dec_t d;
    logic [9:0] word;
    logic [9:0] pin;
    word   = a[11:2];
    pin    = word - CTRL_FIRST_WORD;
    d.kind = ACC_NONE;
    d.grp  = bank_grp_e'(a[7:5]);
    d.idx  = 8'd0;
    if (a[1:0] == 2'b00) begin
      if (a[11:8] == 4'h0) begin
        if (a[7:5] != 3'd7 && int'(a[4:2]) < nbanks) begin
          d.kind = ACC_BANK;
          d.idx  = {5'd0, a[4:2]};
        end
      end else if (a[11:8] <= 4'h4) begin
        if (int'(pin) < nbanks * BANK_PINS) begin
          d.kind = ACC_CTRL;
          d.idx  = pin[7:0];
        end
      end else if (a[11:5] == LOCK_PAGE) begin
        if (int'(a[4:2]) < nbanks) begin
          d.kind = ACC_LOCK;
          d.idx  = {5'd0, a[4:2]};
        end
      end else if (word == PASS_WORD) begin
        d.kind = ACC_PASS;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/pinbank_lock.sv
module pinbank_lock
  import pinbank_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  acc_kind_e            kind,
  input  logic [7:0]           idx,
  input  logic [BUS_W-1:0]     wdata,
  output logic                 armed,
  output logic [NUM_BANKS-1:0] unlocked
);

  logic                 armed_d;
  logic [NUM_BANKS-1:0] unlocked_d;

  // any write consumes the arm; only a correct password re-arms
  always_comb begin
    armed_d    = armed;
    unlocked_d = unlocked;
    if (wr_en) begin
      armed_d = (kind == ACC_PASS) && (wdata == PASSKEY);
      if (armed && kind == ACC_LOCK) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (int'(idx) == b) begin
            if (wdata == CODE_OPEN)      unlocked_d[b] = 1'b1;
            else if (wdata == CODE_SHUT) unlocked_d[b] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      unlocked <= '0;
    end else if (wr_en) begin
      armed    <= armed_d;
      unlocked <= unlocked_d;
    end
  end

endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
  import pinbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic                 clr_en,
  input  logic                 mask_en,
  input  logic                 unmask_en,
  input  logic                 ack_en,
  input  logic [BUS_W-1:0]     wdata,
  input  logic [BANK_PINS-1:0] pad,
  output logic [BANK_PINS-1:0] out_q,
  output logic [BANK_PINS-1:0] mask_q,
  output logic [BANK_PINS-1:0] sync_q,
  output logic [BANK_PINS-1:0] ack_q
);

  logic [BANK_PINS-1:0] out_d;
  logic [BANK_PINS-1:0] mask_d;
  logic [BANK_PINS-1:0] ack_d;
  logic [BANK_PINS-1:0] meta_q;
  logic                 out_ce;
  logic                 mask_ce;

  assign out_ce  = set_en | clr_en;
  assign mask_ce = mask_en | unmask_en;

  always_comb begin
    out_d = out_q;
    if (set_en)      out_d = out_q | wdata;
    else if (clr_en) out_d = out_q & ~wdata;
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_en)        mask_d = wdata;
    else if (unmask_en) mask_d = mask_q & ~wdata;
  end

  assign ack_d = ack_en ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_ce) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= '0;
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      ack_q  <= ack_d;
      meta_q <= pad;
      sync_q <= meta_q;
    end
  end

endmodule

// File: rtl/pinbank_cfg.sv
module pinbank_cfg #(
  parameter int          CTRL_W  = 9,
  parameter logic [31:0] RST_VAL = 32'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] cfg_q
);

  logic [CTRL_W-1:0] cfg_d;

  assign cfg_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RST_VAL[CTRL_W-1:0];
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/pinbank_regfile.sv
module pinbank_regfile
  import pinbank_pkg::*;
#(
  parameter  int NUM_BANKS = 8,
  parameter  int CTRL_W    = 9,
  localparam int NUM_PINS  = NUM_BANKS * BANK_PINS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]        pad_in,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [NUM_PINS*CTRL_W-1:0] pin_cfg,
  input  logic [NUM_PINS-1:0]        irq_pend_in,
  output logic [NUM_PINS-1:0]        irq_mask,
  output logic [NUM_PINS-1:0]        irq_ack
);

  localparam logic [31:0] CFG_RESET = 32'd1;  // input direction

  acc_dec_t             dec;
  logic                 armed;
  logic [NUM_BANKS-1:0] unlocked;

  logic [BANK_PINS-1:0] out_arr  [NUM_BANKS];
  logic [BANK_PINS-1:0] mask_arr [NUM_BANKS];
  logic [BANK_PINS-1:0] sync_arr [NUM_BANKS];
  logic [BANK_PINS-1:0] ack_arr  [NUM_BANKS];
  logic [CTRL_W-1:0]    cfg_arr  [NUM_PINS];

  assign dec = decode_addr(bus_addr, NUM_BANKS);

  pinbank_lock #(.NUM_BANKS(NUM_BANKS)) lock_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .kind     (dec.kind),
    .idx      (dec.idx),
    .wdata    (bus_wdata),
    .armed    (armed),
    .unlocked (unlocked)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr && unlocked[b] && (dec.kind == ACC_BANK)
                 && (int'(dec.idx) == b);

    pinbank_bank bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (hit && dec.grp == GRP_OUT_SET),
      .clr_en    (hit && dec.grp == GRP_OUT_CLR),
      .mask_en   (hit && dec.grp == GRP_IRQ_MASK),
      .unmask_en (hit && dec.grp == GRP_IRQ_UNMASK),
      .ack_en    (hit && dec.grp == GRP_IRQ_STAT),
      .wdata     (bus_wdata),
      .pad       (pad_in[b*BANK_PINS +: BANK_PINS]),
      .out_q     (out_arr[b]),
      .mask_q    (mask_arr[b]),
      .sync_q    (sync_arr[b]),
      .ack_q     (ack_arr[b])
    );

    assign pin_out [b*BANK_PINS +: BANK_PINS] = out_arr[b];
    assign irq_mask[b*BANK_PINS +: BANK_PINS] = mask_arr[b];
    assign irq_ack [b*BANK_PINS +: BANK_PINS] = ack_arr[b];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int PIN_BANK = p / BANK_PINS;
    logic wr_hit;
    assign wr_hit = bus_wr && unlocked[PIN_BANK] && (dec.kind == ACC_CTRL)
                    && (int'(dec.idx) == p);

    pinbank_cfg #(.CTRL_W(CTRL_W), .RST_VAL(CFG_RESET)) cfg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_hit),
      .wdata (bus_wdata[CTRL_W-1:0]),
      .cfg_q (cfg_arr[p])
    );

    assign pin_cfg[p*CTRL_W +: CTRL_W] = cfg_arr[p];
    assign pin_oe[p] = ~cfg_arr[p][0];
  end

  // read path: combinational from the addressed register
  always_comb begin
    bus_rdata = '0;
    unique case (dec.kind)
      ACC_BANK: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (int'(dec.idx) == b) begin
            case (dec.grp)
              GRP_OUT_STAT:   bus_rdata = out_arr[b];
              GRP_IN_STAT:    bus_rdata = sync_arr[b];
              GRP_IRQ_STAT:   bus_rdata = irq_pend_in[b*BANK_PINS +: BANK_PINS];
              GRP_IRQ_MASK,
              GRP_IRQ_UNMASK: bus_rdata = mask_arr[b];
              default:        bus_rdata = '0;
            endcase
          end
        end
      end
      ACC_CTRL: begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (int'(dec.idx) == p) bus_rdata[CTRL_W-1:0] = cfg_arr[p];
        end
      end
      ACC_LOCK: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (int'(dec.idx) == b) bus_rdata = unlocked[b] ? CODE_OPEN : CODE_SHUT;
        end
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pinbank_regfile_chk.sv
module pinbank_regfile_chk
  import pinbank_pkg::*;
#(
  parameter  int NUM_BANKS = 8,
  parameter  int CTRL_W    = 9,
  localparam int NUM_PINS  = NUM_BANKS * BANK_PINS
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_wr,
  input logic [BUS_W-1:0]           bus_wdata,
  input logic [BUS_W-1:0]           bus_rdata,
  input logic [NUM_PINS-1:0]        pad_in,
  input logic [NUM_PINS-1:0]        pin_out,
  input logic [NUM_PINS*CTRL_W-1:0] pin_cfg,
  input logic [NUM_PINS-1:0]        irq_mask,
  input logic [NUM_PINS-1:0]        irq_ack,
  input logic                       armed,
  input logic [NUM_BANKS-1:0]       unlocked
);

  logic [NUM_PINS-1:0]        pin_open;
  logic [NUM_PINS*CTRL_W-1:0] cfg_open;
  logic [1:0]                 age_q;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      pin_open[p] = unlocked[p / BANK_PINS];
      for (int k = 0; k < CTRL_W; k++) cfg_open[p*CTRL_W + k] = unlocked[p / BANK_PINS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R3: lock state moves only on an armed write to the lock page
  assert_lock_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unlocked) |-> ($past(bus_wr) && $past(armed) && $past(bus_addr[11:5]) == LOCK_PAGE));

  assert_locked_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ $past(pin_out)) & ~$past(pin_open)) == '0);

  assert_locked_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_mask ^ $past(irq_mask)) & ~$past(pin_open)) == '0);

  assert_locked_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_cfg ^ $past(pin_cfg)) & ~$past(cfg_open)) == '0);

  assert_set_drives_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == 12'h040 && unlocked[0])
      |-> ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clear_drives_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == 12'h060 && unlocked[0])
      |-> ((pin_out[31:0] & $past(bus_wdata)) == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sync
    assert_input_two_flop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && bus_addr == 12'(32'h20 + 4*b))
        |-> bus_rdata == $past(pad_in[b*BANK_PINS +: BANK_PINS], 2));
  end

  assert_ack_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack != '0) |-> $past(bus_wr));

endmodule

bind pinbank_regfile pinbank_regfile_chk #(.NUM_BANKS(NUM_BANKS), .CTRL_W(CTRL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pin_out   (pin_out),
  .pin_cfg   (pin_cfg),
  .irq_mask  (irq_mask),
  .irq_ack   (irq_ack),
  .armed     (armed),
  .unlocked  (unlocked)
);

// File: tb/pinbank_regfile_tb.sv
`timescale 1ns/1ps
module pinbank_regfile_tb_top;

  localparam int NB = 2;
  localparam int CW = 9;
  localparam int NP = NB * 32;

  logic            clk;
  logic            rst_n;
  logic [11:0]     bus_addr;
  logic            bus_wr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   pad_in;
  logic [NP-1:0]   pin_out;
  logic [NP-1:0]   pin_oe;
  logic [NP*CW-1:0] pin_cfg;
  logic [NP-1:0]   irq_pend_in;
  logic [NP-1:0]   irq_mask;
  logic [NP-1:0]   irq_ack;

  int total = 0;
  int bad   = 0;
  logic [NP-1:0] out_m;

  pinbank_regfile #(.NUM_BANKS(NB), .CTRL_W(CW)) dut_i (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
    .pad_in, .pin_out, .pin_oe, .pin_cfg, .irq_pend_in, .irq_mask, .irq_ack
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    #1;
    chk(tag, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  task automatic open_bank(input int b, input logic [31:0] code);
    wr(12'h520, 32'h00A5A501);
    wr(12'(32'h500 + 4*b), code);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    pad_in = '0; irq_pend_in = '0; out_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 irq_mask", irq_mask, '1);
    chk("R1 irq_ack", irq_ack, '0);
    rd(12'h500, 32'hFFFFFFFF, "R1 bank0 locked");
    rd(12'h504, 32'hFFFFFFFF, "R1 bank1 locked");
    rd(12'h100, 32'd1, "R1 ctrl pin0");
    rd(12'h1FC, 32'd1, "R1 ctrl pin63");

    // R4 writes to a locked bank are dropped
    wr(12'h040, 32'hFFFFFFFF);
    chk("R4 set locked", pin_out, '0);
    wr(12'h100, 32'h0);
    rd(12'h100, 32'd1, "R4 ctrl locked");
    chk("R4 oe locked", pin_oe, '0);
    wr(12'h0C0, 32'hFFFFFFFF);
    chk("R4 unmask locked", irq_mask, '1);
    wr(12'h080, 32'h0000FFFF);
    chk("R4 ack locked", irq_ack, '0);

    // R3 arming rules
    wr(12'h500, 32'h0);
    rd(12'h500, 32'hFFFFFFFF, "R3 no password");
    wr(12'h520, 32'h00A5A500);
    wr(12'h500, 32'h0);
    rd(12'h500, 32'hFFFFFFFF, "R3 wrong password");
    wr(12'h520, 32'h00A5A501);
    wr(12'h044, 32'h1);
    wr(12'h500, 32'h0);
    rd(12'h500, 32'hFFFFFFFF, "R3 intervening write");
    open_bank(0, 32'h12345678);
    rd(12'h500, 32'hFFFFFFFF, "R3 unknown code");

    // R2 unlock bank 0 via double password
    wr(12'h520, 32'h00A5A501);
    open_bank(0, 32'h0);
    rd(12'h500, 32'h0, "R2 bank0 open");
    rd(12'h504, 32'hFFFFFFFF, "R2 bank1 still locked");

    // R5 walking-one set, R6 walking-one clear
    for (int i = 0; i < 32; i++) begin
      wr(12'h040, 32'd1 << i);
      out_m[i] = 1'b1;
      chk($sformatf("R5 set bit %0d", i), pin_out, out_m);
    end
    for (int i = 0; i < 32; i += 3) begin
      wr(12'h060, 32'd1 << i);
      out_m[i] = 1'b0;
      chk($sformatf("R6 clear bit %0d", i), pin_out, out_m);
    end
    wr(12'h060, 32'h0);
    chk("R6 zero clear", pin_out, out_m);
    wr(12'h060, 32'hFFFFFFFF);
    out_m[31:0] = '0;
    wr(12'h040, 32'hA5A5_5A5A);
    out_m[31:0] = out_m[31:0] | 32'hA5A5_5A5A;
    wr(12'h060, 32'h0F0F_0F0F);
    out_m[31:0] = out_m[31:0] & ~32'h0F0F_0F0F;
    chk("R5 R6 pattern", pin_out, out_m);

    // R7 readback
    rd(12'h000, out_m[31:0], "R7 out status bank0");
    rd(12'h004, 32'h0, "R7 out status bank1");
    rd(12'h040, 32'h0, "R7 set reads zero");

    // R9 every control word
    open_bank(1, 32'h0);
    for (int p = 0; p < NP; p++) begin
      logic [31:0] d;
      d = 32'hABC0_0000 | ((p * 37 + 2) & 32'h1FF);
      wr(12'(32'h100 + 4*p), d);
      rd(12'(32'h100 + 4*p), d & 32'h1FF, $sformatf("R9 ctrl pin %0d", p));
      chk($sformatf("R9 oe pin %0d", p), {63'd0, pin_oe[p]}, {63'd0, ~d[0]});
      chk($sformatf("R9 cfg pin %0d", p), {55'd0, pin_cfg[p*CW +: CW]}, {55'd0, d[8:0]});
    end

    // R2 relock bank1 and R4 ignored write
    open_bank(1, 32'hFFFFFFFF);
    rd(12'h504, 32'hFFFFFFFF, "R2 bank1 relocked");
    wr(12'h1A0, 32'h1FF);
    rd(12'h1A0, ((40 * 37 + 2) & 32'h1FF), "R4 ctrl pin40 locked");
    wr(12'h044, 32'hFFFFFFFF);
    chk("R4 set bank1 locked", pin_out, out_m);

    // R8 synchroniser depth
    for (int k = 0; k < 4; k++) begin
      logic [NP-1:0] prev, nxt;
      prev = pad_in;
      nxt  = {32'h1357_9BDF ^ (32'h1111_1111 * k), 32'h8000_0001 << k};
      @(negedge clk);
      pad_in = nxt;
      bus_addr = 12'h020;
      @(negedge clk); #1;
      chk("R8 one edge bank0", {32'd0, bus_rdata}, {32'd0, prev[31:0]});
      @(negedge clk); #1;
      chk("R8 two edges bank0", {32'd0, bus_rdata}, {32'd0, nxt[31:0]});
      rd(12'h024, nxt[63:32], "R8 bank1");
    end

    // R10 mask load and mask clear
    wr(12'h0A0, 32'hF0F0_3C3C);
    chk("R10 mask load", irq_mask, {32'hFFFFFFFF, 32'hF0F0_3C3C});
    wr(12'h0C0, 32'h3000_0C04);
    chk("R10 mask clear", irq_mask, {32'hFFFFFFFF, 32'hC0F0_3038});
    rd(12'h0A0, 32'hC0F0_3038, "R10 mask read");
    rd(12'h0C0, 32'hC0F0_3038, "R10 mask clear read");
    wr(12'h0A4, 32'h0);
    chk("R4 mask bank1 locked", irq_mask, {32'hFFFFFFFF, 32'hC0F0_3038});

    // R11 status read and acknowledge pulse
    irq_pend_in = {32'hDEAD_0001, 32'h0000_F00F};
    rd(12'h080, 32'h0000_F00F, "R11 pend bank0");
    rd(12'h084, 32'hDEAD_0001, "R11 pend bank1");
    wr(12'h080, 32'h0000_F00F);
    chk("R11 ack pulse", irq_ack, {32'd0, 32'h0000_F00F});
    @(negedge clk);
    chk("R11 ack one cycle", irq_ack, '0);
    wr(12'h084, 32'hFFFF_FFFF);
    chk("R11 ack locked bank", irq_ack, '0);

    // R12 out-of-range addresses
    wr(12'h048, 32'hFFFF_FFFF);
    chk("R12 bank2 set", pin_out, out_m);
    rd(12'h048, 32'h0, "R12 bank2 read");
    rd(12'h0E0, 32'h0, "R12 spare group");
    rd(12'h290, 32'h0, "R12 pin 100 ctrl");
    rd(12'h508, 32'h0, "R12 bank2 lock");

    // R2 relock bank0, set ignored afterwards
    open_bank(0, 32'hFFFFFFFF);
    rd(12'h500, 32'hFFFFFFFF, "R2 bank0 relocked");
    wr(12'h040, 32'hFFFF_FFFF);
    chk("R4 set after relock", pin_out, out_m);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule